// File: doc/BRIEF.md
# Cascadable Down-Counting Timer Bank

The block holds four 8-bit down counters. Each one has a mode byte, a base (reload) byte and a read-only count byte, all reached over a small register bus that takes byte, halfword and word accesses. A running timer takes one step down for each cycle in which the shared tick input is high. After the number of steps set by its divisor, it reloads from its base byte and raises a one-cycle interrupt pulse.

Any timer above timer 0 can select cascade mode. It then joins the timer below it, and the group acts as one counter of 16, 24 or 32 bits. The lowest timer of the group heads it, starts and stops it, and supplies the low byte of the divisor. Each cascaded timer above it supplies the next byte. The interrupt of the group leaves on the output of its highest member. Mode writes that break the configuration rules are rejected, and a one-cycle error pulse reports them.

Top module: `tmr_bank`

## Requirements
- R1: A mode write that sets count enable (bit 7) and load (bit 6) together raises `err_o` in the next cycle, and the mode register keeps its previous value.
- R2: A mode write with any of bits 5..2 nonzero raises `err_o`, and the mode register keeps its previous value.
- R3: Clock select is mode bits 1..0, and code 3 means cascade. Selecting cascade on timer 0 is rejected with `err_o`. Enabling a head timer while a cascade member above it has count enable clear is also rejected with `err_o`, and that timer then neither starts nor interrupts.
- R4: While a timer is stopped, a write to its base byte also loads its count byte, so reading the count returns the base value.
- R5: A base write to a running timer leaves the running count unchanged. The new value is used at the next reload.
- R6: A running timer with divisor D raises its interrupt on every D-th tick. Its count reads D right after start and D-k after k ticks.
- R7: Each cascade member adds its base byte above the head. Timer n+k gives bits 8k+7..8k of the divisor, and the group ends at the first timer above the head that is not in cascade mode.
- R8: The interrupt of a cascade group appears only on its highest-numbered member.
- R9: Region is address bits 3..2: 0 for mode, 1 for base, 2 for count. The timer index is address bits 1..0. A halfword access at index 0 or 2 places the lower-numbered timer in data bits 15..8. A word access at index 0 places timer 0 in bits 31..24 and timer 3 in bits 7..0. Size is encoded 0 for byte, 1 for halfword, 2 for word.
- R10: Base writes use the same byte lanes as reads.
- R11: Clearing count enable stops the group with no further interrupt and returns each count byte of the group to its base value. Setting count enable again restarts the count from the full divisor.
- R12: A divisor of zero, whether present at start or reached at a reload, leaves the timer idle with no interrupt.
- R13: A misaligned or unsupported access, a mode write wider than a byte, and any write to the count region raise `err_o` and change no register.
- R14: Counting advances only in cycles where `tick_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Count step enable for all timers |
| bus_sel_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 4 | Region (bits 3..2) and timer index (bits 1..0) |
| bus_size_i | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational, zero when not reading |
| err_o | output | 1 | One-cycle pulse after a rejected access |
| irq_o | output | 4 | One-cycle interrupt pulse per timer |

## Verification
The assertions are checked on every cycle. They cover the following: no stored mode ever holds the illegal enable-and-load pair, a reserved bit or a cascaded timer 0. A bad enable-and-load write is always followed by an error pulse. A stopped non-cascaded timer always shows its base in its counter. Interrupts appear only after a tick, only on a timer whose upper neighbour is not cascaded, and only on an enabled timer. Only the bench scenarios can show the arithmetic: exact divisor periods, borrow across bytes, lane packing, deferred base reloads, and restart after a stop.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    // Clock select codes held in mode bits 1..0; only the chain code is special.
    typedef enum logic [1:0] {
        CS_TICK_A = 2'd0,
        CS_TICK_B = 2'd1,
        CS_TICK_C = 2'd2,
        CS_CHAIN  = 2'd3
    } clk_sel_e;

    // Mode byte layout.
    typedef struct packed {
        logic       run_en;   // bit 7
        logic       load;     // bit 6
        logic [3:0] rsvd;     // bits 5..2
        clk_sel_e   csel;     // bits 1..0
    } mode_t;

    typedef enum logic [1:0] {
        RG_MODE = 2'd0,
        RG_BASE = 2'd1,
        RG_CNT  = 2'd2,
        RG_NONE = 2'd3
    } region_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } size_e;

    // Static legality of a mode byte written to a given timer position.
    function automatic logic mode_static_ok(input mode_t m, input logic is_first);
        logic ok;
        ok = 1'b1;
        if (m.run_en && m.load) ok = 1'b0;
        if (m.rsvd != 4'd0) ok = 1'b0;
        if (is_first && (m.csel == CS_CHAIN)) ok = 1'b0;
        return ok;
    endfunction

endpackage

// File: rtl/tmr_bus_lane.sv
module tmr_bus_lane
    import tmr_pkg::*;
#(
    parameter int NT = 4,
    parameter int BW = 8,
    parameter int IW = 2,
    parameter int AW = 4,
    parameter int DW = 32
) (
    input  logic [AW-1:0]         addr,
    input  logic [1:0]            size,
    input  logic [DW-1:0]         wdata,
    input  logic [NT-1:0][BW-1:0] rd_bytes,
    output region_e               region,
    output logic [IW-1:0]         idx,
    output logic                  fmt_ok,
    output logic [NT-1:0]         lane_en,
    output logic [NT-1:0][BW-1:0] lane_wr,
    output logic [DW-1:0]         rdata
);

    int nb;
    int rel;
    int ln;

    always_comb begin
        region = region_e'(addr[AW-1:IW]);
        idx    = addr[IW-1:0];
        nb     = 1 << size;
        fmt_ok = (size != 2'd3) && (nb <= NT) && ((int'(idx) % nb) == 0)
                 && ((int'(idx) + nb) <= NT) && (region != RG_NONE);
        rdata  = '0;
        rel    = 0;
        ln     = 0;
        for (int j = 0; j < NT; j++) begin
            rel        = j - int'(idx);
            lane_en[j] = fmt_ok && (rel >= 0) && (rel < nb);
            lane_wr[j] = '0;
            if (lane_en[j]) begin
                // lowest timer index lands in the most significant lane
                ln = nb - 1 - rel;
                lane_wr[j]          = wdata[ln*BW +: BW];
                rdata[ln*BW +: BW]  = rd_bytes[j];
            end
        end
    end

endmodule

// File: rtl/tmr_chain.sv
module tmr_chain
    import tmr_pkg::*;
#(
    parameter int NT = 4,
    parameter int BW = 8,
    parameter int IW = 2
) (
    input  logic                  tick_i,
    input  mode_t [NT-1:0]        mode,
    input  logic [NT-1:0][BW-1:0] cnt,
    input  logic [NT-1:0][BW-1:0] base,
    input  logic [NT-1:0]         run,
    output logic [NT-1:0]         casc,
    output logic [NT-1:0]         last,
    output logic [NT-1:0][IW-1:0] head,
    output logic [NT-1:0]         act,
    output logic [NT-1:0]         fire,
    output logic [NT-1:0]         borrow,
    output logic [NT-1:0]         base_nz,
    output logic [NT-1:0]         members_ok
);

    logic [NT-1:0] above_zero;

    always_comb begin
        for (int i = 0; i < NT; i++) begin
            casc[i] = (i != 0) && (mode[i].csel == CS_CHAIN);
        end

        // walk downward: facts about the part of a group above each timer
        last[NT-1]       = 1'b1;
        above_zero[NT-1] = 1'b1;
        base_nz[NT-1]    = (base[NT-1] != '0);
        members_ok[NT-1] = 1'b1;
        for (int i = NT - 2; i >= 0; i--) begin
            last[i]       = !casc[i+1];
            above_zero[i] = last[i] || ((cnt[i+1] == '0) && above_zero[i+1]);
            base_nz[i]    = (base[i] != '0) || (!last[i] && base_nz[i+1]);
            members_ok[i] = last[i] || (mode[i+1].run_en && members_ok[i+1]);
        end

        // walk upward: group head and borrow ripple
        head[0]   = '0;
        borrow[0] = tick_i && run[0];
        for (int i = 1; i < NT; i++) begin
            head[i]   = casc[i] ? head[i-1] : IW'(i);
            borrow[i] = casc[i] ? (borrow[i-1] && (cnt[i-1] == '0))
                                : (tick_i && run[i]);
        end

        for (int i = 0; i < NT; i++) begin
            act[i]  = run[head[i]];
            fire[i] = tick_i && run[i] && !casc[i]
                      && (cnt[i] == BW'(1)) && above_zero[i];
        end
    end

endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
    import tmr_pkg::*;
#(
    parameter int NT = 4,
    parameter int BW = 8          // mode byte layout requires 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick_i,
    input  logic                 bus_sel_i,
    input  logic                 bus_we_i,
    input  logic [$clog2(NT)+1:0] bus_addr_i,
    input  logic [1:0]           bus_size_i,
    input  logic [NT*BW-1:0]     bus_wdata_i,
    output logic [NT*BW-1:0]     bus_rdata_o,
    output logic                 err_o,
    output logic [NT-1:0]        irq_o
);

    localparam int IW = $clog2(NT);
    localparam int AW = IW + 2;
    localparam int DW = NT * BW;

    mode_t [NT-1:0]        mode_q;
    logic  [NT-1:0][BW-1:0] base_q;
    logic  [NT-1:0][BW-1:0] cnt_q;
    logic  [NT-1:0]         run_q;
    logic  [NT-1:0]         irq_q;
    logic                   err_q;

    region_e               region;
    logic [IW-1:0]         idx;
    logic                  fmt_ok;
    logic [NT-1:0]         lane_en;
    logic [NT-1:0][BW-1:0] lane_wr;
    logic [DW-1:0]         rdata_raw;
    logic [NT-1:0][BW-1:0] rd_bytes;

    logic [NT-1:0]         casc, last, act, fire, borrow, base_nz, members_ok;
    logic [NT-1:0][IW-1:0] head;

    always_comb begin
        unique case (region)
            RG_MODE: rd_bytes = mode_q;
            RG_BASE: rd_bytes = base_q;
            RG_CNT:  rd_bytes = cnt_q;
            default: rd_bytes = '0;
        endcase
    end

    tmr_bus_lane #(.NT(NT), .BW(BW), .IW(IW), .AW(AW), .DW(DW)) u_lane (
        .addr     (bus_addr_i),
        .size     (bus_size_i),
        .wdata    (bus_wdata_i),
        .rd_bytes (rd_bytes),
        .region   (region),
        .idx      (idx),
        .fmt_ok   (fmt_ok),
        .lane_en  (lane_en),
        .lane_wr  (lane_wr),
        .rdata    (rdata_raw)
    );

    tmr_chain #(.NT(NT), .BW(BW), .IW(IW)) u_chain (
        .tick_i     (tick_i),
        .mode       (mode_q),
        .cnt        (cnt_q),
        .base       (base_q),
        .run        (run_q),
        .casc       (casc),
        .last       (last),
        .head       (head),
        .act        (act),
        .fire       (fire),
        .borrow     (borrow),
        .base_nz    (base_nz),
        .members_ok (members_ok)
    );

    // ---------------- access decode ----------------
    logic          wr_acc;
    logic          wr_mode;
    logic          mode_bad;
    logic          mode_go;
    mode_t         mval;
    logic          bus_err;
    logic [NT-1:0] reach;
    logic [NT-1:0] base_wr;

    always_comb begin
        wr_acc   = bus_sel_i && bus_we_i;
        mval     = mode_t'(lane_wr[idx]);
        wr_mode  = wr_acc && fmt_ok && (region == RG_MODE)
                   && (size_e'(bus_size_i) == SZ_BYTE);
        mode_bad = !mode_static_ok(mval, idx == '0)
                   || (mval.run_en && (mval.csel != CS_CHAIN) && !members_ok[idx]);
        mode_go  = wr_mode && !mode_bad;

        bus_err = bus_sel_i && !fmt_ok;
        if (wr_acc && fmt_ok) begin
            if ((region == RG_MODE) && (size_e'(bus_size_i) != SZ_BYTE)) bus_err = 1'b1;
            if (region == RG_CNT) bus_err = 1'b1;
            if (wr_mode && mode_bad) bus_err = 1'b1;
        end

        // timers from the written one upward that belong to its group
        for (int j = 0; j < NT; j++) begin
            if (j == int'(idx))      reach[j] = 1'b1;
            else if (j > int'(idx))  reach[j] = (j > 0) ? (reach[j-1] && casc[j]) : 1'b0;
            else                     reach[j] = 1'b0;
            base_wr[j] = wr_acc && fmt_ok && (region == RG_BASE) && lane_en[j];
        end
    end

    // ---------------- state ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            base_q <= '0;
            cnt_q  <= '0;
            run_q  <= '0;
            irq_q  <= '0;
            err_q  <= 1'b0;
        end else begin
            err_q <= bus_err;
            for (int j = 0; j < NT; j++) begin
                irq_q[j] <= last[j] && fire[head[j]];

                if (mode_go && (int'(idx) == j)) begin
                    mode_q[j] <= mval;
                end

                if (base_wr[j]) begin
                    base_q[j] <= lane_wr[j];
                end

                if (mode_go && reach[j]) begin
                    cnt_q[j] <= base_q[j];
                end else if (base_wr[j] && !act[j]) begin
                    cnt_q[j] <= lane_wr[j];
                end else if (fire[head[j]]) begin
                    cnt_q[j] <= base_q[j];
                end else if (borrow[j]) begin
                    cnt_q[j] <= cnt_q[j] - BW'(1);
                end

                if (mode_go && (int'(idx) == j)) begin
                    run_q[j] <= mval.run_en && (mval.csel != CS_CHAIN) && base_nz[j];
                end else if (fire[j]) begin
                    run_q[j] <= base_nz[j];
                end
            end
        end
    end

    assign bus_rdata_o = (bus_sel_i && !bus_we_i) ? rdata_raw : '0;
    assign err_o       = err_q;
    assign irq_o       = irq_q;

endmodule

// File: rtl/tmr_bank_chk.sv
module tmr_bank_chk
    import tmr_pkg::*;
#(
    parameter int NT = 4,
    parameter int BW = 8
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    tick_i,
    input logic                    bus_sel_i,
    input logic                    bus_we_i,
    input logic [$clog2(NT)+1:0]   bus_addr_i,
    input logic [1:0]              bus_size_i,
    input logic [NT*BW-1:0]        bus_wdata_i,
    input logic                    err_o,
    input logic [NT-1:0]           irq_o,
    input mode_t [NT-1:0]          mode_q,
    input logic [NT-1:0][BW-1:0]   base_q,
    input logic [NT-1:0][BW-1:0]   cnt_q
);

    localparam int IW = $clog2(NT);

    AST_BAD_PAIR_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        (bus_sel_i && bus_we_i && (bus_addr_i[IW+1:IW] == 2'd0) && (bus_size_i == 2'd0)
         && bus_wdata_i[7] && bus_wdata_i[6]) |=> err_o); // R1

    AST_T0_NEVER_CHAINED: assert property (@(posedge clk) disable iff (rst)
        mode_q[0].csel != CS_CHAIN); // R3

    for (genvar i = 0; i < NT; i++) begin : g_tmr
        AST_NO_PAIR_STORED: assert property (@(posedge clk) disable iff (rst)
            !(mode_q[i].run_en && mode_q[i].load)); // R1

        AST_RSVD_CLEAR: assert property (@(posedge clk) disable iff (rst)
            mode_q[i].rsvd == 4'd0); // R2

        AST_STOPPED_SHOWS_BASE: assert property (@(posedge clk) disable iff (rst)
            (mode_q[i].csel != CS_CHAIN && !mode_q[i].run_en) |-> (cnt_q[i] == base_q[i])); // R4

        AST_IRQ_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
            irq_o[i] |-> $past(tick_i)); // R14

        AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
            (irq_o[i] && $past(mode_q[i].csel != CS_CHAIN)) |-> $past(mode_q[i].run_en)); // R11

        if (i < NT - 1) begin : g_up
            AST_IRQ_TOP_ONLY: assert property (@(posedge clk) disable iff (rst)
                irq_o[i] |-> $past(mode_q[i+1].csel != CS_CHAIN)); // R8
        end
    end

endmodule

bind tmr_bank tmr_bank_chk #(.NT(NT), .BW(BW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .tick_i      (tick_i),
    .bus_sel_i   (bus_sel_i),
    .bus_we_i    (bus_we_i),
    .bus_addr_i  (bus_addr_i),
    .bus_size_i  (bus_size_i),
    .bus_wdata_i (bus_wdata_i),
    .err_o       (err_o),
    .irq_o       (irq_o),
    .mode_q      (mode_q),
    .base_q      (base_q),
    .cnt_q       (cnt_q)
);

// File: tb/tmr_bank_tb.sv
module tmr_bank_tb;

    localparam int CLK_P = 10;
    localparam logic [1:0] RMODE = 2'd0, RBASE = 2'd1, RCNT = 2'd2;
    localparam logic [1:0] SB = 2'd0, SH = 2'd1, SW = 2'd2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_i = 1'b0;
    logic        bus_sel_i = 1'b0;
    logic        bus_we_i = 1'b0;
    logic [3:0]  bus_addr_i = '0;
    logic [1:0]  bus_size_i = '0;
    logic [31:0] bus_wdata_i = '0;
    logic [31:0] bus_rdata_o;
    logic        err_o;
    logic [3:0]  irq_o;

    int n_chk = 0;
    int n_fail = 0;
    int irq_cnt [4];

    always #(CLK_P/2) clk = ~clk;

    tmr_bank u_dut (
        .clk(clk), .rst(rst), .tick_i(tick_i),
        .bus_sel_i(bus_sel_i), .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i),
        .bus_size_i(bus_size_i), .bus_wdata_i(bus_wdata_i),
        .bus_rdata_o(bus_rdata_o), .err_o(err_o), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] rg, input int ix, input logic [1:0] sz,
                      input logic [31:0] d, output logic e);
        @(negedge clk);
        bus_sel_i = 1'b1; bus_we_i = 1'b1;
        bus_addr_i = {rg, 2'(ix)}; bus_size_i = sz; bus_wdata_i = d;
        @(posedge clk);
        #1;
        e = err_o;
        bus_sel_i = 1'b0; bus_we_i = 1'b0;
    endtask

    task automatic rd(input logic [1:0] rg, input int ix, input logic [1:0] sz,
                      output logic [31:0] d);
        @(negedge clk);
        bus_sel_i = 1'b1; bus_we_i = 1'b0;
        bus_addr_i = {rg, 2'(ix)}; bus_size_i = sz;
        #1;
        d = bus_rdata_o;
        bus_sel_i = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            tick_i = 1'b1;
            @(posedge clk);
            #1;
            tick_i = 1'b0;
            for (int i = 0; i < 4; i++) irq_cnt[i] += int'(irq_o[i]);
        end
    endtask

    task automatic clr_irq();
        for (int i = 0; i < 4; i++) irq_cnt[i] = 0;
    endtask

    task automatic clear_all();
        logic e;
        for (int i = 0; i < 4; i++) wr(RMODE, i, SB, 32'h0, e);
        clr_irq();
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(RMODE, 0, SW, d); chk("R9 reset mode word", d, 32'h0);
        rd(RBASE, 0, SW, d); chk("R9 reset base word", d, 32'h0);
        rd(RCNT, 0, SW, d);  chk("R9 reset count word", d, 32'h0);
        chk("R13 reset err", {31'd0, err_o}, 32'h0);
        chk("R8 reset irq", {28'd0, irq_o}, 32'h0);
    endtask

    task automatic t_basic();
        logic e; logic [31:0] d;
        clear_all();
        wr(RBASE, 0, SB, 32'h3, e);
        rd(RCNT, 0, SB, d); chk("R4 stopped base loads count", d, 32'h3);
        wr(RMODE, 0, SB, 32'h80, e); chk("R6 legal start no err", {31'd0, e}, 32'h0);
        rd(RCNT, 0, SB, d); chk("R6 count after start", d, 32'h3);
        repeat (3) @(negedge clk);
        rd(RCNT, 0, SB, d); chk("R14 no tick no step", d, 32'h3);
        ticks(1); rd(RCNT, 0, SB, d); chk("R6 after 1 tick", d, 32'h2);
        ticks(1); rd(RCNT, 0, SB, d); chk("R6 after 2 ticks", d, 32'h1);
        chk("R6 no irq before period", irq_cnt[0], 0);
        ticks(1); chk("R6 irq on 3rd tick", irq_cnt[0], 1);
        rd(RCNT, 0, SB, d); chk("R6 reload after underflow", d, 32'h3);
        ticks(6); chk("R6 irq every 3 ticks", irq_cnt[0], 3);
    endtask

    task automatic t_base_run();
        logic e; logic [31:0] d;
        clear_all();
        wr(RBASE, 1, SB, 32'h4, e);
        wr(RMODE, 1, SB, 32'h80, e);
        ticks(1); rd(RCNT, 1, SB, d); chk("R6 timer1 step", d, 32'h3);
        wr(RBASE, 1, SB, 32'h9, e);
        rd(RCNT, 1, SB, d); chk("R5 running count kept", d, 32'h3);
        ticks(2); rd(RCNT, 1, SB, d); chk("R5 old period continues", d, 32'h1);
        chk("R5 no early irq", irq_cnt[1], 0);
        ticks(1); chk("R5 irq at old period", irq_cnt[1], 1);
        rd(RCNT, 1, SB, d); chk("R5 reload uses new base", d, 32'h9);
        ticks(9); chk("R5 new period", irq_cnt[1], 2);
    endtask

    task automatic t_cascade();
        logic e; logic [31:0] d;
        clear_all();
        wr(RBASE, 0, SB, 32'h02, e);
        wr(RBASE, 1, SB, 32'h01, e);
        wr(RBASE, 2, SB, 32'h00, e);
        wr(RBASE, 3, SB, 32'h55, e);
        wr(RMODE, 1, SB, 32'h83, e);
        wr(RMODE, 3, SB, 32'h83, e);
        wr(RMODE, 0, SB, 32'h80, e); chk("R7 chain start no err", {31'd0, e}, 32'h0);
        rd(RCNT, 0, SH, d); chk("R7 combined start", d, 32'h0201);
        ticks(1);   rd(RCNT, 0, SH, d); chk("R7 combined step", d, 32'h0101);
        ticks(256); rd(RCNT, 0, SH, d); chk("R7 borrow across bytes", d, 32'h0100);
        chk("R7 no irq before 258", irq_cnt[1], 0);
        ticks(1);
        chk("R8 irq on top of chain", irq_cnt[1], 1);
        chk("R8 no irq on head", irq_cnt[0], 0);
        rd(RCNT, 0, SH, d); chk("R7 chain reload", d, 32'h0201);
        rd(RCNT, 3, SB, d); chk("R7 chain stops at non-cascade", d, 32'h55);
        chk("R7 detached timer silent", irq_cnt[3], 0);

        clear_all();
        wr(RBASE, 0, SW, 32'h01000000, e);
        wr(RMODE, 3, SB, 32'h83, e);
        wr(RMODE, 2, SB, 32'h83, e);
        wr(RMODE, 1, SB, 32'h83, e);
        wr(RMODE, 0, SB, 32'h80, e);
        ticks(5);
        chk("R8 four-wide irq on timer3", irq_cnt[3], 5);
        chk("R8 four-wide none below", irq_cnt[0] + irq_cnt[1] + irq_cnt[2], 0);
    endtask

    task automatic t_errors();
        logic e; logic [31:0] d;
        clear_all();
        wr(RMODE, 2, SB, 32'hC0, e); chk("R1 enable+load flagged", {31'd0, e}, 32'h1);
        rd(RMODE, 2, SB, d); chk("R1 mode unchanged", d, 32'h0);
        wr(RMODE, 2, SB, 32'h10, e); chk("R2 reserved flagged", {31'd0, e}, 32'h1);
        rd(RMODE, 2, SB, d); chk("R2 mode unchanged", d, 32'h0);
        wr(RMODE, 0, SB, 32'h03, e); chk("R3 timer0 cascade flagged", {31'd0, e}, 32'h1);
        rd(RMODE, 0, SB, d); chk("R3 timer0 mode unchanged", d, 32'h0);
        wr(RBASE, 0, SB, 32'h21, e);
        wr(RMODE, 1, SB, 32'h03, e); chk("R3 idle cascade member legal", {31'd0, e}, 32'h0);
        wr(RMODE, 0, SB, 32'h80, e); chk("R3 member disabled flagged", {31'd0, e}, 32'h1);
        rd(RMODE, 0, SB, d); chk("R3 head not enabled", d, 32'h0);
        ticks(3);
        rd(RCNT, 0, SB, d); chk("R3 head not counting", d, 32'h21);
        chk("R3 no irq", irq_cnt[0] + irq_cnt[1], 0);
        wr(RMODE, 0, SH, 32'h0080, e); chk("R13 wide mode write flagged", {31'd0, e}, 32'h1);
        rd(RMODE, 0, SB, d); chk("R13 wide mode write ignored", d, 32'h0);
        wr(RBASE, 1, SW, 32'hDEADBEEF, e); chk("R13 misaligned flagged", {31'd0, e}, 32'h1);
        rd(RBASE, 0, SB, d); chk("R13 misaligned ignored", d, 32'h21);
        wr(RCNT, 0, SB, 32'h77, e); chk("R13 count write flagged", {31'd0, e}, 32'h1);
        rd(RCNT, 0, SB, d); chk("R13 count write ignored", d, 32'h21);
    endtask

    task automatic t_lanes();
        logic e; logic [31:0] d;
        clear_all();
        wr(RBASE, 0, SW, 32'h11223344, e); chk("R10 word write ok", {31'd0, e}, 32'h0);
        rd(RBASE, 0, SB, d); chk("R10 timer0 is top lane", d, 32'h11);
        rd(RBASE, 3, SB, d); chk("R10 timer3 is low lane", d, 32'h44);
        rd(RBASE, 2, SH, d); chk("R9 half read idx2", d, 32'h3344);
        wr(RBASE, 2, SH, 32'h0000AABB, e);
        rd(RBASE, 2, SB, d); chk("R10 half write upper to timer2", d, 32'hAA);
        rd(RBASE, 3, SB, d); chk("R10 half write lower to timer3", d, 32'hBB);
        rd(RCNT, 0, SW, d); chk("R4 R9 counts follow bases", d, 32'h1122AABB);
    endtask

    task automatic t_stop();
        logic e; logic [31:0] d;
        clear_all();
        wr(RBASE, 0, SB, 32'h5, e);
        wr(RMODE, 0, SB, 32'h80, e);
        ticks(2); rd(RCNT, 0, SB, d); chk("R11 running", d, 32'h3);
        wr(RMODE, 0, SB, 32'h00, e);
        rd(RCNT, 0, SB, d); chk("R11 stop shows base", d, 32'h5);
        ticks(10); chk("R11 no irq while stopped", irq_cnt[0], 0);
        wr(RMODE, 0, SB, 32'h80, e);
        rd(RCNT, 0, SB, d); chk("R11 restart full divisor", d, 32'h5);
        ticks(4); chk("R11 no irq before full period", irq_cnt[0], 0);
        ticks(1); chk("R11 irq after full period", irq_cnt[0], 1);
    endtask

    task automatic t_zero();
        logic e; logic [31:0] d;
        clear_all();
        wr(RBASE, 2, SB, 32'h0, e);
        wr(RMODE, 2, SB, 32'h80, e);
        ticks(20); chk("R12 zero divisor idle", irq_cnt[2], 0);
        rd(RCNT, 2, SB, d); chk("R12 zero count held", d, 32'h0);
        wr(RBASE, 2, SB, 32'h2, e);
        wr(RMODE, 2, SB, 32'h80, e);
        ticks(1);
        wr(RBASE, 2, SB, 32'h0, e);
        ticks(1); chk("R12 last irq before zero reload", irq_cnt[2], 1);
        ticks(5); chk("R12 idle after zero reload", irq_cnt[2], 1);
        rd(RCNT, 2, SB, d); chk("R12 count at zero", d, 32'h0);
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    endtask

    initial begin
        clr_irq();
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_basic();
        t_base_run();
        t_cascade();
        t_errors();
        t_lanes();
        t_stop();
        t_zero();
        report();
        $finish;
    end

    initial begin
        #(CLK_P * 50000);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        report();
        $finish;
    end

endmodule